// File: doc/BRIEF.md
# Offset-Corrected Moving Average Filter

This block smooths a stream of signed ADC samples for one channel. Each incoming sample first has a programmable signed offset removed. The corrected value then enters a circular sample store, and a running sum is updated. The average is the sum shifted right by the log2 of the window length.

The window length (tap count) is held in an internal register. It is loaded through a write strobe and accepts only powers of two from 1 to 128. The block produces nothing until the window has filled. Loading a different tap count clears the stored samples, the sum and the fill count, and the fill-up starts again.

Top module: `offset_avg_filter`

## Requirements
- R1: The corrected sample is `in_sample - offset`, both 12-bit two's complement, formed as a 13-bit signed value without saturation. A positive offset lowers the result and a negative offset raises it.
- R2: After reset the tap count is 4, so the first valid output follows the fourth accepted sample.
- R3: A tap-count write takes effect only if `taps_wdata` is a power of two between 1 and 128. Any other value (for example 0, 3 or 200) is ignored, and the current window and data are kept.
- R4: `out_valid` stays low until the number of samples accepted since reset or restart equals the tap count.
- R5: Once the window is full, `out_sample` is the sum of the most recent N corrected samples, arithmetically shifted right by log2(N). Negative sums therefore round toward minus infinity.
- R6: `out_valid` is a single-cycle pulse. It is registered on the clock edge that accepts an input with `in_valid` high, and it never rises in a cycle that follows no accepted input.
- R7: A legal write of a tap count different from the current one clears the sample store, the sum and the fill count. A sample presented in that same cycle is discarded. `out_valid` is low in the following cycle.
- R8: A write of the same tap count as the current one does not restart the filter.
- R9: While `rst_n` is low at a clock edge, `out_valid` and `out_sample` become 0 and the tap count returns to 4.
- R10: With a tap count of 128, the oldest sample is taken from the slot about to be overwritten, so the window slides correctly at full depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 12 | Raw sample, two's complement |
| offset | input | 12 | Signed offset subtracted from each sample |
| taps_wr | input | 1 | Tap-count write strobe |
| taps_wdata | input | 8 | Requested tap count |
| out_valid | output | 1 | Averaged result strobe |
| out_sample | output | 13 | Averaged result, two's complement |

## Verification
The main path is driven by a ten-sample vector table with a window of four and a non-zero offset. Its rising and then falling values show whether the offset is applied, whether the oldest sample is subtracted at the right distance, and whether a negative sum with a fractional average rounds down rather than toward zero.

A window of one with extreme offsets separates correct 13-bit widening from wrap-around. A ramp into a 128-deep window shows whether the read and write addresses coincide correctly at full depth.

Tap writes of a new value, the same value, and illegal values, some with a sample in the same cycle, tell a true restart apart from a spurious one.

// File: rtl/ofa_pkg.sv
// Package ofa_pkg
// Shared helpers for the offset-corrected moving-average filter.
// Assumes tap counts fit in 16 bits.
package ofa_pkg;

    // True when v is a non-zero power of two.
    function automatic logic is_pow2(input logic [15:0] v);
        return (v != 16'd0) && ((v & (v - 16'd1)) == 16'd0);
    endfunction

    // Index of the highest set bit; log2 for powers of two.
    function automatic logic [3:0] log2_of(input logic [15:0] v);
        logic [3:0] r;
        r = 4'd0;
        for (int i = 0; i < 16; i++) begin
            if (v[i]) r = 4'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/ofa_tap_ctrl.sv
// Module ofa_tap_ctrl
// Holds the window length and its log2. Accepts only legal writes
// (power of two, 1..MAX_TAPS). Raises restart for one cycle when a
// legal write changes the value.
// Assumes RESET_TAPS is itself legal.
module ofa_tap_ctrl #(
    parameter int MAX_TAPS   = 128,
    parameter int RESET_TAPS = 4,
    parameter int TAP_W      = $clog2(MAX_TAPS) + 1,
    parameter int LOG_W      = $clog2(TAP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [TAP_W-1:0] wdata,
    output logic [TAP_W-1:0] taps_q,
    output logic [LOG_W-1:0] taps_log_q,
    output logic             restart
);
    import ofa_pkg::*;

    logic legal;
    logic [3:0] wlog;

    // Classify the requested value and flag a real change.
    always_comb begin
        legal   = is_pow2(16'(wdata)) && (int'(wdata) <= MAX_TAPS);
        wlog    = log2_of(16'(wdata));
        restart = wr && legal && (wdata != taps_q);
    end

    // Tap-count register with its precomputed shift amount.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps_q     <= TAP_W'(RESET_TAPS);
            taps_log_q <= LOG_W'($clog2(RESET_TAPS));
        end else if (restart) begin
            taps_q     <= wdata;
            taps_log_q <= wlog[LOG_W-1:0];
        end
    end
endmodule

// File: rtl/ofa_delay_mem.sv
// Module ofa_delay_mem
// Circular store of corrected samples. The write pointer advances on
// each write. The read port returns the entry written `taps` writes ago,
// at address wptr - taps modulo DEPTH. Clear zeroes every entry and
// the pointer.
// Assumes DEPTH is a power of two and taps <= DEPTH.
module ofa_delay_mem #(
    parameter int DATA_W = 13,
    parameter int DEPTH  = 128,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int TAP_W  = ADDR_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     wr_en,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic [TAP_W-1:0]         taps,
    output logic signed [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] rd_addr;
    logic signed [DATA_W-1:0] store [DEPTH];

    // Oldest-sample address; a full-depth window wraps onto wptr.
    always_comb begin
        rd_addr = wptr - taps[ADDR_W-1:0];
        rd_data = store[rd_addr];
    end

    // Write pointer: advances per write, returns to 0 on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) wptr <= '0;
        else if (wr_en)      wptr <= wptr + ADDR_W'(1);
    end

    // One register per entry so that clear empties the whole store.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                     store[gi] <= '0;
            else if (wr_en && wptr == ADDR_W'(gi))   store[gi] <= wr_data;
        end
    end
endmodule

// File: rtl/ofa_accum.sv
// Module ofa_accum
// Running-sum engine. Adds each accepted sample. Once the fill count
// equals the tap count, it also subtracts the oldest sample. It
// registers the shifted average with a one-cycle valid pulse.
// Assumes `oldest` is the entry written `taps` accepts earlier.
module ofa_accum #(
    parameter int DATA_W = 13,
    parameter int SUM_W  = 20,
    parameter int TAP_W  = 8,
    parameter int LOG_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     accept,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic signed [DATA_W-1:0] oldest,
    input  logic [TAP_W-1:0]         taps,
    input  logic [LOG_W-1:0]         taps_log,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data,
    output logic [TAP_W-1:0]         fill_cnt
);
    logic signed [SUM_W-1:0] sum_q, sum_next, add_ext, sub_ext, shifted;
    logic [TAP_W-1:0]        fill_next;
    logic                    full;

    // Next sum and fill count for an accepted sample.
    always_comb begin
        full      = (fill_cnt == taps);
        add_ext   = SUM_W'(in_data);
        sub_ext   = full ? SUM_W'(oldest) : '0;
        sum_next  = sum_q + add_ext - sub_ext;
        fill_next = full ? fill_cnt : fill_cnt + TAP_W'(1);
        shifted   = sum_next >>> taps_log;
    end

    // Sum, fill count and registered output.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum_q     <= '0;
            fill_cnt  <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (accept) begin
            sum_q     <= sum_next;
            fill_cnt  <= fill_next;
            out_valid <= (fill_next == taps);
            out_data  <= shifted[DATA_W-1:0];
        end else begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/offset_avg_filter.sv
// Module offset_avg_filter (top)
// Subtracts a signed offset from each sample, then averages over a
// power-of-two window. Output is suppressed until the window fills.
// A change of window length restarts the whole datapath.
// Assumes SAMPLE_W-bit inputs and a power-of-two MAX_TAPS.
module offset_avg_filter #(
    parameter int SAMPLE_W   = 12,
    parameter int MAX_TAPS   = 128,
    parameter int RESET_TAPS = 4,
    localparam int ADDR_W    = $clog2(MAX_TAPS),
    localparam int TAP_W     = ADDR_W + 1,
    localparam int LOG_W     = $clog2(TAP_W),
    localparam int CORR_W    = SAMPLE_W + 1,
    localparam int SUM_W     = CORR_W + ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [SAMPLE_W-1:0] offset,
    input  logic                taps_wr,
    input  logic [TAP_W-1:0]    taps_wdata,
    output logic                out_valid,
    output logic [CORR_W-1:0]   out_sample
);
    logic [TAP_W-1:0]         taps_q;
    logic [LOG_W-1:0]         taps_log_q;
    logic                     restart;
    logic                     accept;
    logic signed [CORR_W-1:0] corrected;
    logic signed [CORR_W-1:0] oldest;
    logic signed [CORR_W-1:0] avg;
    logic [TAP_W-1:0]         fill_cnt;

    // Offset correction widened by one bit; restart drops the sample.
    always_comb begin
        corrected = $signed({in_sample[SAMPLE_W-1], in_sample})
                  - $signed({offset[SAMPLE_W-1], offset});
        accept    = in_valid && !restart;
    end

    ofa_tap_ctrl #(
        .MAX_TAPS(MAX_TAPS), .RESET_TAPS(RESET_TAPS),
        .TAP_W(TAP_W), .LOG_W(LOG_W)
    ) u_taps (
        .clk(clk), .rst_n(rst_n), .wr(taps_wr), .wdata(taps_wdata),
        .taps_q(taps_q), .taps_log_q(taps_log_q), .restart(restart)
    );

    ofa_delay_mem #(
        .DATA_W(CORR_W), .DEPTH(MAX_TAPS), .ADDR_W(ADDR_W), .TAP_W(TAP_W)
    ) u_mem (
        .clk(clk), .rst_n(rst_n), .clear(restart), .wr_en(accept),
        .wr_data(corrected), .taps(taps_q), .rd_data(oldest)
    );

    ofa_accum #(
        .DATA_W(CORR_W), .SUM_W(SUM_W), .TAP_W(TAP_W), .LOG_W(LOG_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(restart), .accept(accept),
        .in_data(corrected), .oldest(oldest), .taps(taps_q),
        .taps_log(taps_log_q), .out_valid(out_valid), .out_data(avg),
        .fill_cnt(fill_cnt)
    );

    assign out_sample = avg;
endmodule

// File: rtl/ofa_checker.sv
// Module ofa_checker
// Temporal properties of offset_avg_filter, attached through bind.
module ofa_checker #(
    parameter int TAP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             restart,
    input logic [TAP_W-1:0] taps_q,
    input logic [TAP_W-1:0] fill_cnt
);
    // R6: a result pulse always follows a presented sample
    assert_valid_after_input_R6: assert property (@(posedge clk)
        disable iff (!rst_n) out_valid |-> $past(in_valid));

    // R7: no result in the cycle after a restart
    assert_restart_quiet_R7: assert property (@(posedge clk)
        disable iff (!rst_n) restart |=> !out_valid);

    // R4: a result only with a full window
    assert_full_before_valid_R4: assert property (@(posedge clk)
        disable iff (!rst_n) out_valid |-> (fill_cnt == taps_q));

    // R3: the held tap count is always a single power of two
    assert_taps_legal_R3: assert property (@(posedge clk)
        disable iff (!rst_n) $countones(taps_q) == 1);

    // R4: the fill count never passes the window
    assert_fill_bounded_R4: assert property (@(posedge clk)
        disable iff (!rst_n) fill_cnt <= taps_q);

    // R9: reset silences the output
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

bind offset_avg_filter ofa_checker #(.TAP_W(TAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .restart(restart), .taps_q(taps_q), .fill_cnt(fill_cnt)
);

// File: tb/offset_avg_filter_test.sv
module offset_avg_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    // Window 4, offset 10: samples, expected valid, expected average.
    localparam int VEC_IN  [NV] = '{14, 18, 22, 26, 30, -2, 100, 50, -90, -90};
    localparam bit VEC_V   [NV] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 1};
    localparam int VEC_OUT [NV] = '{0, 0, 0, 10, 14, 9, 28, 34, 4, -18};

    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic [11:0] in_sample = '0;
    logic [11:0] offset = '0;
    logic        taps_wr = 0;
    logic [7:0]  taps_wdata = '0;
    logic        out_valid;
    logic [12:0] out_sample;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    offset_avg_filter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .offset(offset), .taps_wr(taps_wr), .taps_wdata(taps_wdata),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic gv, input int go,
                         input logic ev, input int eo);
        checks++;
        if (gv !== ev || (ev && go != eo)) begin
            failures++;
            $display("FAIL %s: got valid=%0b value=%0d, expected valid=%0b value=%0d",
                     req, gv, go, ev, eo);
        end
    endtask

    // Present one sample, return the output one edge later.
    task automatic send(input int s, output logic v, output int o);
        @(negedge clk);
        in_valid = 1; in_sample = s[11:0];
        @(posedge clk); #1;
        v = out_valid; o = $signed(out_sample);
        in_valid = 0;
    endtask

    // Write the tap count, optionally with a sample in the same cycle.
    task automatic wr_taps(input int t, input bit with_s, input int s, output logic v);
        @(negedge clk);
        taps_wr = 1; taps_wdata = t[7:0]; in_valid = with_s; in_sample = s[11:0];
        @(posedge clk); #1;
        v = out_valid;
        taps_wr = 0; in_valid = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic v;
        int o;
        bit early;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset", out_valid, 0, 1'b0, 0);
        checks++;
        if (out_sample !== 13'd0) begin
            failures++;
            $display("FAIL R9 reset value: got %0d expected 0", out_sample);
        end
        @(negedge clk); rst_n = 1; offset = 12'd10;

        // R1 R2 R4 R5: table walk, default window of four.
        for (int i = 0; i < NV; i++) begin
            send(VEC_IN[i], v, o);
            check("R5 table", v, o, VEC_V[i], VEC_OUT[i]);
        end

        // R6: no sample, no pulse.
        @(negedge clk); @(posedge clk); #1;
        check("R6 idle", out_valid, 0, 1'b0, 0);

        // R8: same value does not restart. Window 40,-100,-100,0 -> -40.
        wr_taps(4, 0, 0, v);
        send(10, v, o);
        check("R8 same taps", v, o, 1'b1, -40);

        // R7: change to 2 with a sample in the same cycle (dropped).
        wr_taps(2, 1, 500, v);
        check("R7 restart quiet", v, 0, 1'b0, 0);
        send(16, v, o);
        check("R7 refill", v, o, 1'b0, 0);
        send(18, v, o);
        check("R7 new window", v, o, 1'b1, 7);

        // R3: illegal writes are ignored. Window 8,2 -> 5.
        wr_taps(3, 0, 0, v);
        wr_taps(0, 0, 0, v);
        wr_taps(200, 0, 0, v);
        send(12, v, o);
        check("R3 illegal ignored", v, o, 1'b1, 5);

        // R1: extreme offsets with a window of one.
        wr_taps(1, 0, 0, v);
        offset = 12'd2047;
        send(-2048, v, o);
        check("R1 low extreme", v, o, 1'b1, -4095);
        @(negedge clk); offset = 12'h800;
        send(2047, v, o);
        check("R1 high extreme", v, o, 1'b1, 4095);
        @(negedge clk); offset = -12'sd5;
        send(-5, v, o);
        check("R1 negative offset", v, o, 1'b1, 0);

        // R10: full-depth window, ramp 0..127 -> 63, then 1000 -> 71.
        @(negedge clk); offset = 12'd0;
        wr_taps(128, 0, 0, v);
        early = 0;
        for (int i = 0; i < 127; i++) begin
            send(i, v, o);
            if (v) early = 1;
        end
        check("R4 no early output at 128", early, 0, 1'b0, 0);
        send(127, v, o);
        check("R10 first full", v, o, 1'b1, 63);
        send(1000, v, o);
        check("R10 slide", v, o, 1'b1, 71);

        // R9 R2: reset mid-run restores a window of four.
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1;
        check("R9 mid reset", out_valid, 0, 1'b0, 0);
        @(negedge clk); rst_n = 1;
        for (int i = 0; i < 3; i++) begin
            send(8, v, o);
            check("R2 default fill", v, o, 1'b0, 0);
        end
        send(12, v, o);
        check("R2 default window", v, o, 1'b1, 9);

        finish_run();
    end
endmodule